// File: doc/BRIEF.md
# Edge Event Sense Detector

This block watches a set of single-bit input levels that have already been synchronized and, where needed, debounced. For each point it records a sticky event flag when the chosen transition appears. Points are grouped in fours, and one polarity bit per group selects rising or falling detection. The flag is held apart from the live level, so software can read back which points saw an event even after the level has returned.

Each point also has an arm bit. A byte-wide write selects one port of eight points. In that byte a 1 arms a point, and a 0 both clears the point's flag and disarms it. Only armed points can raise a flag. A single interrupt line is asserted while any flag is set and the global interrupt enable is high.

Polarity arrives through two write-only paths. One path carries a byte for the lower eight groups. The other carries four bits for the upper four groups, which the bank-select path supplies.

Top module: `edge_event_sense`

## Requirements
- R1: An armed point whose selected transition is seen between two rising clock edges has its bit in `evt_flag` set after the second of those edges, whatever the point's level is afterwards.
- R2: Group g covers points 4g to 4g+3. Polarity bit 0 detects only low-to-high changes and bit 1 detects only high-to-low changes.
- R3: A `pol_lo_we` write replaces the polarity of groups 0 to 7 with `pol_lo_d` (bit g sets group g). A `pol_hi_we` write replaces groups 8 to 11 with `pol_hi_d` (bit k sets group 8+k). The new polarity applies from the following cycle on.
- R4: A set flag stays set until a clear write reaches its point.
- R5: An `arm_we` write with `arm_port` = p acts on points 8p to 8p+7, with `arm_data` bit j acting on point 8p+j. A 1 arms the point and leaves its flag as it is. An edge in the same cycle as the arming write is not recorded.
- R6: An `arm_data` bit of 0 in such a write clears that point's flag and disarms it, so later edges on that point set nothing.
- R7: When a clear and a detected edge on the same point fall in the same cycle, the clear wins and the flag ends at 0.
- R8: `irq` is high exactly when `irq_en` is high and at least one flag is set.
- R9: An `arm_we` write with `arm_port` of 6 or 7 changes no flag and no arm bit.
- R10: Changing a group's polarity while the point's level stays constant sets no flag.
- R11: After reset all flags and arm bits are 0, all groups detect rising edges, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 48 | Synchronized point levels |
| pol_lo_we | input | 1 | Write strobe for polarity of groups 0-7 |
| pol_lo_d | input | 8 | Polarity bits for groups 0-7 |
| pol_hi_we | input | 1 | Write strobe for polarity of groups 8-11 |
| pol_hi_d | input | 4 | Polarity bits for groups 8-11 |
| arm_we | input | 1 | Arm/clear write strobe |
| arm_port | input | 3 | Port index of the arm/clear write |
| arm_data | input | 8 | Arm (1) or clear-and-disarm (0) per point |
| irq_en | input | 1 | Global interrupt enable |
| evt_flag | output | 48 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
A level change driven before a rising edge is compared with the previous level at that edge, so the flag appears one clock after the change is driven. Arm, clear and polarity writes also take effect at that same edge, while `irq` follows the flags and `irq_en` without further delay. The bench drives every input at the falling edge. For each cycle it pushes one predicted record, and a monitor pops and compares that record shortly after the next rising edge, so every comparison lands after the one register stage.

// File: rtl/eesd_pkg.sv
package eesd_pkg;

  // Edge match for one point: neg=0 wants 0->1, neg=1 wants 1->0.
  function automatic logic edge_match(input logic neg, input logic was, input logic now);
    return neg ? (was & ~now) : (~was & now);
  endfunction

  // Next flag value for one point.
  function automatic logic flag_next(input logic cur, input logic cap, input logic clr);
    return (cur | cap) & ~clr;
  endfunction

  // Next arm value for one point.
  function automatic logic arm_next(input logic cur, input logic set, input logic clr);
    return (cur | set) & ~clr;
  endfunction

endpackage

// File: rtl/eesd_polarity.sv
module eesd_polarity #(
  parameter int NGRP   = 12,
  parameter int LO_GRP = 8,
  parameter int GRP_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lo_we,
  input  logic [LO_GRP-1:0]       lo_d,
  input  logic                    hi_we,
  input  logic [NGRP-LO_GRP-1:0]  hi_d,
  output logic [NGRP*GRP_W-1:0]   pt_neg
);
  localparam int HI_GRP = NGRP - LO_GRP;

  logic [LO_GRP-1:0] lo_q;
  logic [HI_GRP-1:0] hi_q;
  logic              past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (lo_we) lo_q <= lo_d;
      if (hi_we) hi_q <= hi_d;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_expand
    if (g < LO_GRP) begin : g_lo
      assign pt_neg[g*GRP_W +: GRP_W] = {GRP_W{lo_q[g]}};
    end else begin : g_hi
      assign pt_neg[g*GRP_W +: GRP_W] = {GRP_W{hi_q[g-LO_GRP]}};
    end
  end

  a_r3_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(lo_we)) |-> (lo_q == $past(lo_d)));
  a_r3_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(hi_we)) |-> (hi_q == $past(hi_d)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(lo_we) && !$past(hi_we)) |-> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/eesd_edge_detect.sv
module eesd_edge_detect #(
  parameter int NPTS = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPTS-1:0] lvl,
  input  logic [NPTS-1:0] neg,
  output logic [NPTS-1:0] hit
);
  import eesd_pkg::*;

  logic [NPTS-1:0] prev_q;
  logic            past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      prev_q  <= lvl;
      past_ok <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPTS; i++) begin : g_pt
    assign hit[i] = edge_match(neg[i], prev_q[i], lvl[i]);
  end

  // R10: no detection without a level change since the last edge
  a_r10_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((hit & ~(lvl ^ $past(lvl))) == '0));

endmodule

// File: rtl/eesd_flag_bank.sv
module eesd_flag_bank #(
  parameter int NPORT  = 6,
  parameter int PORT_W = 8,
  parameter int PIDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT*PORT_W-1:0] hit,
  input  logic                    we,
  input  logic [PIDX_W-1:0]       port,
  input  logic [PORT_W-1:0]       data,
  output logic [NPORT*PORT_W-1:0] flag
);
  import eesd_pkg::*;
  localparam int NPTS = NPORT * PORT_W;

  logic [NPTS-1:0] arm_q;
  logic [NPTS-1:0] flag_q;
  logic [NPTS-1:0] set_vec;
  logic [NPTS-1:0] clr_vec;
  logic [NPTS-1:0] cap_vec;
  logic            past_ok;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel = we && (port == PIDX_W'(p));
    assign set_vec[p*PORT_W +: PORT_W] = sel ? data  : '0;
    assign clr_vec[p*PORT_W +: PORT_W] = sel ? ~data : '0;
  end

  assign cap_vec = hit & arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q   <= '0;
      flag_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      for (int i = 0; i < NPTS; i++) begin
        flag_q[i] <= flag_next(flag_q[i], cap_vec[i], clr_vec[i]);
        arm_q[i]  <= arm_next(arm_q[i], set_vec[i], clr_vec[i]);
      end
    end
  end

  assign flag = flag_q;

  // R7: a clear always leaves the flag at 0
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((flag_q & $past(clr_vec)) == '0));
  // R4: set flags without a clear stay set
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(flag_q & ~clr_vec) & ~flag_q) == '0));
  // R1: a newly set flag needs a detected edge
  a_r1_flag_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((flag_q & ~$past(flag_q)) & ~$past(hit)) == '0));
  // R5: a newly set flag needs the point armed beforehand
  a_r5_flag_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((flag_q & ~$past(flag_q)) & ~$past(arm_q)) == '0));
  // R9: out-of-range port writes change no arm bit
  a_r9_bad_port: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(we) && ($past(int'(port)) >= NPORT)) |-> $stable(arm_q));

endmodule

// File: rtl/edge_event_sense.sv
module edge_event_sense #(
  parameter int NPORT  = 6,
  parameter int PORT_W = 8,
  parameter int GRP_W  = 4,
  parameter int LO_GRP = 8,
  parameter int PIDX_W = 3,
  parameter int NPTS   = NPORT * PORT_W,
  parameter int NGRP   = NPTS / GRP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPTS-1:0]        pin_lvl,
  input  logic                   pol_lo_we,
  input  logic [LO_GRP-1:0]      pol_lo_d,
  input  logic                   pol_hi_we,
  input  logic [NGRP-LO_GRP-1:0] pol_hi_d,
  input  logic                   arm_we,
  input  logic [PIDX_W-1:0]      arm_port,
  input  logic [PORT_W-1:0]      arm_data,
  input  logic                   irq_en,
  output logic [NPTS-1:0]        evt_flag,
  output logic                   irq
);
  logic [NPTS-1:0] pt_neg;
  logic [NPTS-1:0] pt_hit;
  logic            any_flag;

  eesd_polarity #(.NGRP(NGRP), .LO_GRP(LO_GRP), .GRP_W(GRP_W)) u_pol (
    .clk(clk), .rst_n(rst_n),
    .lo_we(pol_lo_we), .lo_d(pol_lo_d),
    .hi_we(pol_hi_we), .hi_d(pol_hi_d),
    .pt_neg(pt_neg)
  );

  eesd_edge_detect #(.NPTS(NPTS)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl(pin_lvl), .neg(pt_neg), .hit(pt_hit)
  );

  eesd_flag_bank #(.NPORT(NPORT), .PORT_W(PORT_W), .PIDX_W(PIDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .hit(pt_hit), .we(arm_we), .port(arm_port), .data(arm_data),
    .flag(evt_flag)
  );

  assign any_flag = |evt_flag;
  assign irq      = irq_en & any_flag;

  // R8: disabled interrupt never asserts; enabled one follows the flags
  a_r8_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  a_r8_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (evt_flag != '0)) |-> irq);
  // R11: nothing pending while in reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (evt_flag == '0));

endmodule

// File: tb/edge_event_sense_tb_top.sv
module edge_event_sense_tb_top;
  localparam int NPTS = 48;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPTS-1:0] pin_lvl = '0;
  logic            pol_lo_we = 1'b0;
  logic [7:0]      pol_lo_d = '0;
  logic            pol_hi_we = 1'b0;
  logic [3:0]      pol_hi_d = '0;
  logic            arm_we = 1'b0;
  logic [2:0]      arm_port = '0;
  logic [7:0]      arm_data = '0;
  logic            irq_en = 1'b0;
  logic [NPTS-1:0] evt_flag;
  logic            irq;

  always #4 clk = ~clk;

  edge_event_sense dut_i (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
    .pol_lo_we(pol_lo_we), .pol_lo_d(pol_lo_d),
    .pol_hi_we(pol_hi_we), .pol_hi_d(pol_hi_d),
    .arm_we(arm_we), .arm_port(arm_port), .arm_data(arm_data),
    .irq_en(irq_en), .evt_flag(evt_flag), .irq(irq)
  );

  typedef struct {
    logic [NPTS-1:0] flag;
    logic            irq;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // model state
  logic [NPTS-1:0] m_flag = '0, m_arm = '0, m_prev = '0;
  logic [11:0]     m_pol = '0;

  task automatic check(input bit ok, input string tag, input logic [NPTS-1:0] act,
                       input logic [NPTS-1:0] expv, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // one cycle: predict from current inputs, push, advance to next falling edge
  task automatic tick(input string tag);
    exp_t e;
    logic [NPTS-1:0] nf, na;
    for (int i = 0; i < NPTS; i++) begin
      logic neg, hitb, setb, clrb;
      neg  = m_pol[i/4];
      hitb = neg ? (m_prev[i] && !pin_lvl[i]) : (!m_prev[i] && pin_lvl[i]);
      setb = arm_we && (arm_port < 6) && (i/8 == int'(arm_port)) && arm_data[i%8];
      clrb = arm_we && (arm_port < 6) && (i/8 == int'(arm_port)) && !arm_data[i%8];
      nf[i] = clrb ? 1'b0 : (m_flag[i] || (hitb && m_arm[i]));
      na[i] = clrb ? 1'b0 : (m_arm[i] || setb);
    end
    m_flag = nf;
    m_arm  = na;
    m_prev = pin_lvl;
    if (pol_lo_we) m_pol[7:0]  = pol_lo_d;
    if (pol_hi_we) m_pol[11:8] = pol_hi_d;
    e.flag = m_flag;
    e.irq  = irq_en && (m_flag != '0);
    e.tag  = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr_arm(input logic [2:0] p, input logic [7:0] d, input string tag);
    arm_we = 1'b1; arm_port = p; arm_data = d;
    tick(tag);
    arm_we = 1'b0;
  endtask

  task automatic wr_pol_lo(input logic [7:0] d, input string tag);
    pol_lo_we = 1'b1; pol_lo_d = d;
    tick(tag);
    pol_lo_we = 1'b0;
  endtask

  task automatic wr_pol_hi(input logic [3:0] d, input string tag);
    pol_hi_we = 1'b1; pol_hi_d = d;
    tick(tag);
    pol_hi_we = 1'b0;
  endtask

  // monitor: compare each predicted record just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(evt_flag === e.flag, e.tag, evt_flag, e.flag, "evt_flag");
        check(irq === e.irq, e.tag, {47'd0, irq}, {47'd0, e.irq}, "irq");
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(evt_flag === '0, "R11", evt_flag, '0, "evt_flag in reset");
    check(irq === 1'b0, "R11", {47'd0, irq}, '0, "irq in reset");
    rst_n  = 1'b1;
    irq_en = 1'b1;
    tick("R11"); tick("R11");

    // R5: arm port 0, then rising edges on points 0-3 (R1, R2)
    wr_arm(3'd0, 8'hFF, "R5");
    pin_lvl[3:0] = 4'hF; tick("R1");
    pin_lvl[3:0] = 4'h0; tick("R2");        // falling on positive groups: nothing new
    tick("R4"); tick("R4");                 // flags stick, level low again

    // R3: 02h makes group 1 (points 4-7) negative
    wr_pol_lo(8'h02, "R3");
    pin_lvl[7:4] = 4'hF; tick("R2");        // rising on negative group: ignored
    pin_lvl[7:4] = 4'h0; tick("R2");        // falling: flags 4-7

    // R6: clear and disarm points 0-3, keep 4-7 armed
    wr_arm(3'd0, 8'hF0, "R6");
    pin_lvl[3:0] = 4'hF; tick("R6");
    pin_lvl[3:0] = 4'h0; tick("R6");

    // R7: clear of point 8 together with its edge; point 9 armed and hit
    wr_arm(3'd1, 8'hFF, "R5");
    pin_lvl[9:8] = 2'b11;
    wr_arm(3'd1, 8'hFE, "R7");
    tick("R7");

    // R8: interrupt gating
    irq_en = 1'b0; tick("R8"); tick("R8");
    irq_en = 1'b1; tick("R8");

    // R3: upper groups via the high path, groups 8 and 10 negative
    wr_arm(3'd4, 8'hFF, "R5");
    wr_arm(3'd5, 8'hFF, "R5");
    wr_pol_hi(4'b0101, "R3");
    pin_lvl[47:32] = 16'hFFFF; tick("R3");
    pin_lvl[47:32] = 16'h0000; tick("R3");

    // R10: polarity change with steady high level on points 20-23
    pin_lvl[23:20] = 4'hF; tick("R10");
    wr_arm(3'd2, 8'hFF, "R5");
    wr_pol_lo(8'h22, "R10");
    tick("R10"); tick("R10");
    wr_pol_lo(8'h02, "R10");
    tick("R10");

    // R9: out-of-range port indices do nothing
    wr_arm(3'd6, 8'h00, "R9");
    wr_arm(3'd7, 8'hFF, "R9");
    pin_lvl[26] = 1'b1; tick("R9");         // port 3 still unarmed

    // R5: edge in the same cycle as arming is not recorded
    pin_lvl[24] = 1'b1;
    wr_arm(3'd3, 8'hFF, "R5");
    pin_lvl[25] = 1'b1; tick("R5");

    // R6/R8: clear everything, interrupt drops
    for (int p = 0; p < 6; p++) wr_arm(3'(p), 8'h00, "R6");
    pin_lvl = ~pin_lvl; tick("R6");
    tick("R8");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule